// File: doc/BRIEF.md
# GPIO Expander Register and Interrupt Core

This block is the register and interrupt core of a 24-pin general-purpose I/O expander. A serial slave front end drives a simple synchronous register bus into it. The bus carries an 8-bit byte address, a write strobe with 8-bit write data, and combinational 8-bit read data. Every pin-wide setting is a 24-bit vector. Each vector is stored as three byte registers at consecutive addresses, with the least significant byte at the lowest address. The pad drivers read the direction, pull and output-latch vectors directly from output ports.

Pin inputs pass through a two-flop synchronizer. The synchronized value is readable over the bus and also feeds a per-pin detector. The detector can be edge- or level-sensitive, and each pin can be set to trigger on high/rising or on low/falling. Detected events latch into a pending vector, and software clears that vector by writing ones to an acknowledge vector. A small state machine drives the interrupt line from the pending vector and a global enable. It has two states:

- `IRQ_IDLE`: the line is not asserted. It moves to `IRQ_ASSERT` when the global enable is set and at least one pending bit is set.
- `IRQ_ASSERT`: the line is asserted. It moves back to `IRQ_IDLE` when either of those conditions goes away.

The interrupt line can be driven push-pull or open-drain, with either polarity.

Top module: `gpx_regcore`

## Requirements
- R1: Address 0x00 always reads 0x7B, and writes to it have no effect. Unmapped addresses read 0x00.
- R2: After reset, every register reads 0x00 except address 0x00. `pin_out`, `pin_dir` and `pin_pull` are zero, and the interrupt line is inactive (`irq_oe` = 0, `irq_val` = 0).
- R3: The following vectors are read/write: direction at 0x60 (1 = output), pull at 0x68 (1 = pull-up), interrupt enable at 0x48, event type at 0x4C (1 = edge) and trigger at 0x50 (1 = rising/high). Each vector spans byte address base+0..base+2, and bit i sits in byte i/8 at bit position i%8. Direction and pull appear on `pin_dir` and `pin_pull`.
- R4: Writing ones to 0x6C..0x6E sets the matching `pin_out` bits. Writing ones to 0x70..0x72 clears them. Zero bits change nothing, and both windows read 0x00.
- R5: The input state at 0x10..0x12 shows `pin_in` through two flops. A value applied before clock edge k is readable after edge k+1 and is not readable after edge k alone.
- R6: For an edge-sensitive pin, a rising edge (trigger 1) or a falling edge (trigger 0) of the synchronized input sets its bit in the pending vector at 0x0C..0x0E. The opposite edge does not. Writes to the pending vector have no effect.
- R7: For a level-sensitive pin, the pending bit sets while the synchronized input equals the trigger bit. If the level still holds after an acknowledge, the bit sets again in the cycle following the acknowledge.
- R8: Writing ones to 0x54..0x56 clears the matching pending bits in that write's cycle, even if an event occurs in the same cycle. The window reads 0x00.
- R9: A pending bit never sets while its interrupt-enable bit is 0, or while bit 0 of 0x40 (function enable) is 0.
- R10: The interrupt line is asserted one cycle after bit 0 of 0x42 is 1 and any pending bit is 1. It is released one cycle after either condition fails.
- R11: Bit 0 of 0x41 selects push-pull (1) or open-drain (0), and bit 1 selects active-high (1) or active-low (0). In push-pull mode `irq_oe` = 1 and `irq_val` is the active level while asserted and its inverse otherwise. In open-drain mode `irq_oe` = 1 only while asserted, and `irq_val` is always the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 24 | Asynchronous pin input levels |
| pin_out | output | 24 | Output latch |
| pin_dir | output | 24 | Direction, 1 = output |
| pin_pull | output | 24 | Pull select, 1 = pull-up |
| irq_oe | output | 1 | Interrupt line output enable |
| irq_val | output | 1 | Interrupt line driven value |

## Verification
The embedded assertions check the following on every clock:

- a pending bit never rises without its enable and the function enable in the previous cycle;
- an acknowledged bit is always clear afterwards;
- set and clear strobes always land on the output latch;
- `IRQ_ASSERT` is only entered from a valid source;
- push-pull mode never tri-states the line.

Only the bench scenarios can show the following:

- edge direction selection and the two-flop latency;
- level re-assertion in the cycle after an acknowledge;
- the exact byte-lane placement;
- the polarity and drive combinations seen at the pins.

// File: rtl/gpx_pkg.sv
`timescale 1ns/1ps
package gpx_pkg;
    localparam logic [7:0] ID_VALUE   = 8'h7B;
    localparam logic [7:0] A_ID       = 8'h00;
    localparam logic [7:0] A_PEND     = 8'h0C;
    localparam logic [7:0] A_STATE    = 8'h10;
    localparam logic [7:0] A_SYSCTL   = 8'h40;
    localparam logic [7:0] A_IRQMODE  = 8'h41;
    localparam logic [7:0] A_GIE      = 8'h42;
    localparam logic [7:0] A_IEN      = 8'h48;
    localparam logic [7:0] A_EVT      = 8'h4C;
    localparam logic [7:0] A_TRIG     = 8'h50;
    localparam logic [7:0] A_ACK      = 8'h54;
    localparam logic [7:0] A_DIR      = 8'h60;
    localparam logic [7:0] A_PULL     = 8'h68;
    localparam logic [7:0] A_SET      = 8'h6C;
    localparam logic [7:0] A_CLR      = 8'h70;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ASSERT = 1'b1
    } irq_state_t;

    function automatic logic in_win(input logic [7:0] a, input logic [7:0] base);
        return a[7:2] == base[7:2];
    endfunction

    function automatic logic [7:0] pick_byte(input logic [31:0] v, input logic [1:0] k);
        logic [7:0] r;
        case (k)
            2'd0: r = v[7:0];
            2'd1: r = v[15:8];
            2'd2: r = v[23:16];
            default: r = v[31:24];
        endcase
        return r;
    endfunction
endpackage

// File: rtl/gpx_sync.sv
`timescale 1ns/1ps
module gpx_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpx_irq_detect.sv
`timescale 1ns/1ps
module gpx_irq_detect #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cur,
    input  logic             gpio_en,
    input  logic [WIDTH-1:0] ien,
    input  logic [WIDTH-1:0] evt,
    input  logic [WIDTH-1:0] trig,
    input  logic [WIDTH-1:0] ack,
    output logic [WIDTH-1:0] pend
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] hit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic edge_hit;
        logic level_hit;
        assign edge_hit  = trig[i] ? (cur[i] & ~prev_q[i]) : (~cur[i] & prev_q[i]);
        assign level_hit = (cur[i] == trig[i]);
        assign hit[i]    = gpio_en & ien[i] & (evt[i] ? edge_hit : level_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= cur;
            pend_q <= (pend_q | hit) & ~ack;
        end
    end

    assign pend = pend_q;

    // R9
    pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~($past(ien) & {WIDTH{$past(gpio_en)}})) == '0);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & $past(ack)) == '0);
endmodule

// File: rtl/gpx_irq_pin.sv
`timescale 1ns/1ps
module gpx_irq_pin
    import gpx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gie,
    input  logic pend_any,
    input  logic push_pull,
    input  logic active_high,
    output logic irq_oe,
    output logic irq_val
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (gie && pend_any)    state_d = IRQ_ASSERT;
            IRQ_ASSERT: if (!(gie && pend_any)) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_oe  = 1'b0;
        irq_val = active_high;
        unique case (state_q)
            IRQ_IDLE: begin
                irq_oe  = push_pull;
                irq_val = push_pull ? ~active_high : active_high;
            end
            IRQ_ASSERT: begin
                irq_oe  = 1'b1;
                irq_val = active_high;
            end
            default: ;
        endcase
    end

    // R10
    assert_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_ASSERT) |-> $past(gie && pend_any));

    // R11
    pp_always_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_oe |-> !push_pull);
endmodule

// File: rtl/gpx_regfile.sv
`timescale 1ns/1ps
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [WIDTH-1:0] pend_i,
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] pull,
    output logic [WIDTH-1:0] ien,
    output logic [WIDTH-1:0] evt,
    output logic [WIDTH-1:0] trig,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] ack_mask,
    output logic             gpio_en,
    output logic             gie,
    output logic             push_pull,
    output logic             active_high
);
    logic [WIDTH-1:0] set_mask, clr_mask;
    logic [1:0]       lane;

    assign lane = addr[1:0];

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            logic sel;
            sel         = we && (lane == 2'(i >> 3)) && wdata[i[2:0]];
            set_mask[i] = sel && in_win(addr, A_SET);
            clr_mask[i] = sel && in_win(addr, A_CLR);
            ack_mask[i] = sel && in_win(addr, A_ACK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= '0; pull <= '0; ien <= '0; evt <= '0; trig <= '0; out_q <= '0;
            gpio_en <= 1'b0; gie <= 1'b0; push_pull <= 1'b0; active_high <= 1'b0;
        end else begin
            if (we && addr == A_SYSCTL)  gpio_en <= wdata[0];
            if (we && addr == A_GIE)     gie     <= wdata[0];
            if (we && addr == A_IRQMODE) begin
                push_pull   <= wdata[0];
                active_high <= wdata[1];
            end
            for (int i = 0; i < WIDTH; i++) begin
                if (we && lane == 2'(i >> 3)) begin
                    if (in_win(addr, A_DIR))  dir[i]  <= wdata[i[2:0]];
                    if (in_win(addr, A_PULL)) pull[i] <= wdata[i[2:0]];
                    if (in_win(addr, A_IEN))  ien[i]  <= wdata[i[2:0]];
                    if (in_win(addr, A_EVT))  evt[i]  <= wdata[i[2:0]];
                    if (in_win(addr, A_TRIG)) trig[i] <= wdata[i[2:0]];
                end
            end
            out_q <= (out_q | set_mask) & ~clr_mask;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (addr == A_ID)            rdata = ID_VALUE;
        else if (addr == A_SYSCTL)   rdata = {7'b0, gpio_en};
        else if (addr == A_IRQMODE)  rdata = {6'b0, active_high, push_pull};
        else if (addr == A_GIE)      rdata = {7'b0, gie};
        else if (in_win(addr, A_PEND))  rdata = pick_byte(32'(pend_i), lane);
        else if (in_win(addr, A_STATE)) rdata = pick_byte(32'(state_i), lane);
        else if (in_win(addr, A_IEN))   rdata = pick_byte(32'(ien), lane);
        else if (in_win(addr, A_EVT))   rdata = pick_byte(32'(evt), lane);
        else if (in_win(addr, A_TRIG))  rdata = pick_byte(32'(trig), lane);
        else if (in_win(addr, A_DIR))   rdata = pick_byte(32'(dir), lane);
        else if (in_win(addr, A_PULL))  rdata = pick_byte(32'(pull), lane);
    end

    // R4
    set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q & $past(set_mask)) == $past(set_mask));

    // R4
    clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q & $past(clr_mask)) == '0);
endmodule

// File: rtl/gpx_regcore.sv
`timescale 1ns/1ps
module gpx_regcore #(
    parameter int PINS        = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [7:0]      bus_addr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_dir,
    output logic [PINS-1:0] pin_pull,
    output logic            irq_oe,
    output logic            irq_val
);
    logic [PINS-1:0] synced, pend, ien, evt, trig, ack_mask;
    logic            gpio_en, gie, push_pull, active_high;

    gpx_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(synced)
    );

    gpx_regfile #(.WIDTH(PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .pend_i(pend), .state_i(synced), .dir(pin_dir),
        .pull(pin_pull), .ien(ien), .evt(evt), .trig(trig), .out_q(pin_out),
        .ack_mask(ack_mask), .gpio_en(gpio_en), .gie(gie), .push_pull(push_pull),
        .active_high(active_high)
    );

    gpx_irq_detect #(.WIDTH(PINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .cur(synced), .gpio_en(gpio_en), .ien(ien),
        .evt(evt), .trig(trig), .ack(ack_mask), .pend(pend)
    );

    gpx_irq_pin u_irq (
        .clk(clk), .rst_n(rst_n), .gie(gie), .pend_any(|pend),
        .push_pull(push_pull), .active_high(active_high),
        .irq_oe(irq_oe), .irq_val(irq_val)
    );
endmodule

// File: tb/gpx_regcore_tb.sv
`timescale 1ns/1ps
module gpx_regcore_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_out, pin_dir, pin_pull;
    logic        irq_oe, irq_val;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpx_regcore u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_dir(pin_dir), .pin_pull(pin_pull),
        .irq_oe(irq_oe), .irq_val(irq_val)
    );

    // {address, write data, expected readback}
    localparam int NV = 13;
    localparam logic [23:0] VEC [NV] = '{
        24'h60_A5_A5, 24'h61_3C_3C, 24'h62_81_81, 24'h68_0F_0F,
        24'h4E_7E_7E, 24'h51_C3_C3, 24'h4A_5A_5A, 24'h54_FF_00,
        24'h6E_00_00, 24'h00_12_7B, 24'h0C_FF_00, 24'h43_FF_00,
        24'h4A_00_00
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R2 reset state
        rd(8'h60, r); chk("R2 dir", r, 8'h00);
        rd(8'h41, r); chk("R2 mode", r, 8'h00);
        chk("R2 pin_out", pin_out, 0);
        chk("R2 irq_oe", irq_oe, 0);
        chk("R2 irq_val", irq_val, 0);
        // R1 identification
        rd(8'h00, r); chk("R1 id", r, 8'h7B);

        // R3 R1 R8 R6 table walk
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][23:16], VEC[v][15:8]);
            rd(VEC[v][23:16], r);
            chk($sformatf("R3 table addr %0h", VEC[v][23:16]), r, VEC[v][7:0]);
        end
        chk("R3 pin_dir", pin_dir, 24'h813CA5);
        chk("R3 pin_pull", pin_pull, 24'h00000F);

        // R4 set / clear
        wr(8'h6C, 8'h11); chk("R4 set low", pin_out, 24'h000011);
        wr(8'h6E, 8'h80); chk("R4 set high", pin_out, 24'h800011);
        wr(8'h70, 8'h01); chk("R4 clear", pin_out, 24'h800010);
        rd(8'h70, r); chk("R4 clr reads 0", r, 8'h00);

        // R5 synchronizer latency
        @(negedge clk); pin_in = 24'h00A000;
        @(negedge clk); rd(8'h11, r); chk("R5 not yet", r, 8'h00);
        @(negedge clk); rd(8'h11, r); chk("R5 visible", r, 8'hA0);

        // R9 function disabled: rising pin0 with ien set gives no pending
        wr(8'h4C, 8'h01); wr(8'h50, 8'h01); wr(8'h48, 8'h01);
        @(negedge clk); pin_in[0] = 1'b1; cyc(4);
        rd(8'h0C, r); chk("R9 gpio off", r, 8'h00);
        wr(8'h40, 8'h01);
        @(negedge clk); pin_in[1] = 1'b1; cyc(4);
        rd(8'h0C, r); chk("R9 ien off", r, 8'h00);
        // R6 rising only
        @(negedge clk); pin_in[0] = 1'b0; cyc(4);
        rd(8'h0C, r); chk("R6 falling ignored", r, 8'h00);
        @(negedge clk); pin_in[0] = 1'b1; cyc(4);
        rd(8'h0C, r); chk("R6 rising", r, 8'h01);
        // R6 falling on pin2
        wr(8'h4C, 8'h05); wr(8'h48, 8'h05);
        @(negedge clk); pin_in[2] = 1'b1; cyc(4);
        rd(8'h0C, r); chk("R6 rise ignored", r, 8'h01);
        @(negedge clk); pin_in[2] = 1'b0; cyc(4);
        rd(8'h0C, r); chk("R6 falling", r, 8'h05);

        // R8 acknowledge
        wr(8'h54, 8'h01); rd(8'h0C, r); chk("R8 ack bit0", r, 8'h04);
        wr(8'h54, 8'h04); rd(8'h0C, r); chk("R8 ack bit2", r, 8'h00);
        rd(8'h54, r); chk("R8 ack reads 0", r, 8'h00);

        // R10 global enable timing
        @(negedge clk); pin_in[0] = 1'b0; cyc(4);
        @(negedge clk); pin_in[0] = 1'b1; cyc(4);
        rd(8'h0C, r); chk("R10 pending", r, 8'h01);
        chk("R10 gie off", irq_oe, 0);
        wr(8'h42, 8'h01);
        chk("R10 one cycle later", irq_oe, 0);
        @(negedge clk);
        chk("R10 asserted", irq_oe, 1);
        chk("R11 od active low", irq_val, 0);
        // R11 drive modes
        wr(8'h41, 8'h03); chk("R11 pp high oe", irq_oe, 1); chk("R11 pp high val", irq_val, 1);
        wr(8'h41, 8'h01); chk("R11 pp low val", irq_val, 0);
        wr(8'h54, 8'h01); @(negedge clk);
        chk("R10 released oe", irq_oe, 1); chk("R11 pp low idle", irq_val, 1);
        wr(8'h41, 8'h00); chk("R11 od idle oe", irq_oe, 0); chk("R11 od idle val", irq_val, 0);

        // R7 level-high on pin8
        wr(8'h51, 8'h01); wr(8'h49, 8'h01);
        cyc(2); rd(8'h0D, r); chk("R7 low no pend", r, 8'h00);
        @(negedge clk); pin_in[8] = 1'b1; cyc(4);
        rd(8'h0D, r); chk("R7 level pend", r, 8'h01);
        wr(8'h55, 8'h01); rd(8'h0D, r); chk("R7 ack cycle", r, 8'h00);
        @(negedge clk); rd(8'h0D, r); chk("R7 re-set", r, 8'h01);
        @(negedge clk); pin_in[8] = 1'b0; cyc(4);
        wr(8'h55, 8'h01); cyc(3); rd(8'h0D, r); chk("R7 level gone", r, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule